// File: doc/BRIEF.md
# ALU Status Flag Register

This block is the condition-code unit of an 8-bit datapath. It joins the combinational arithmetic and logic unit that computes each result to the eight-bit status word that records facts about that result. The ALU takes two operands and a four-bit operation code. After each valid operation, the unit writes the carry, zero, negative, overflow, sign and half-carry flags it derives from the result. Later conditional branches can then test these flags directly, so a separate compare is often not needed.

Two status bits are not driven by ALU results. The first is a global interrupt enable. Interrupt entry and a clear instruction drop it. Return-from-interrupt and a set instruction raise it. The second is a single-bit scratch store. A bit-store operation fills it from a chosen operand bit. A bit-load operation uses it to overwrite a chosen bit of an operand. Software can load the whole word at once. Nothing in the unit saves or restores the word around interrupts.

Top module: `sf_status_unit`

## Requirements
- R1: Status bit positions, from bit 7 down to bit 0, are: interrupt enable, scratch bit, half carry, sign, overflow, negative, zero, carry. All bits are 0 after the active-low reset, whether it comes at start-up or in mid-run.
- R2: With sw_we_i high, the next status_o equals sw_wdata_i. This write overrides every ALU, interrupt and bit-store event in the same cycle.
- R3: After every ALU operation, the sign bit equals negative XOR overflow.
- R4: Opcode 0 (add) and opcode 1 (add with carry-in taken from the status carry) produce the wrapped sum. They set carry to the carry out of bit 7, half carry to the carry out of bit 3, and overflow to two's complement overflow.
- R5: Opcode 2 (subtract) and opcode 3 (subtract with borrow-in taken from the status carry) produce the wrapped difference. Carry is set when A < B + borrow-in, unsigned. Half carry is set when the low nibble of A is less than the low nibble of B plus the borrow-in. Overflow is set on signed overflow.
- R6: For opcodes 1 and 3, a non-zero result clears zero, and a zero result leaves zero at its previous value. All other valid opcodes set zero exactly when the result is zero.
- R7: Opcodes 4 (AND), 5 (OR) and 6 (XOR) clear overflow, update zero, negative and sign, and leave carry and half carry unchanged.
- R8: Opcodes 7 (A+1) and 8 (A-1) ignore operand B. They leave carry and half carry unchanged. Overflow is set only for an increment to 0x80 or a decrement to 0x7F.
- R9: Interrupt entry or the clear request forces the enable bit to 0. Return-from-interrupt or the set request forces it to 1. A clearing source wins over a setting source in the same cycle. None of these touch the other seven bits.
- R10: A bit-store writes opa_i[bit_sel_i] into the scratch bit on the next clock edge.
- R11: bld_data_o equals opa_i with bit bit_sel_i replaced by the current scratch bit, in the same cycle.
- R12: Opcodes 9 to 15 give result 0 and change no flag. With alu_valid_i low, no ALU flag changes, although result_o still follows the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alu_valid_i | input | 1 | Commit this cycle's ALU flags |
| alu_op_i | input | 4 | Operation code |
| opa_i | input | 8 | Operand A; also the bit-store source and bit-load target |
| opb_i | input | 8 | Operand B |
| result_o | output | 8 | Combinational ALU result |
| sw_we_i | input | 1 | Whole-word software write |
| sw_wdata_i | input | 8 | Software write data |
| irq_take_i | input | 1 | Interrupt entry |
| irq_ret_i | input | 1 | Return from interrupt |
| ie_set_i | input | 1 | Set-enable request |
| ie_clr_i | input | 1 | Clear-enable request |
| bst_i | input | 1 | Bit-store strobe |
| bit_sel_i | input | 3 | Bit index for bit-store and bit-load |
| bld_data_o | output | 8 | Operand A with selected bit replaced by the scratch bit |
| status_o | output | 8 | Status word |

## Verification
result_o and bld_data_o are combinational. The bench checks them 1 ns after it drives the inputs, before the next rising edge. Every status update lands on the first rising edge after its stimulus. The bench therefore reads status_o 2 ns after that edge, once the register has settled and before any new stimulus. Each table vector first loads a known status word by software write, one edge earlier, so that the sticky-zero and unchanged-carry cases start from a known prior value.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8
  } alu_op_e;

  localparam int unsigned SW_W = 8;
  localparam int unsigned FB_C = 0;
  localparam int unsigned FB_Z = 1;
  localparam int unsigned FB_N = 2;
  localparam int unsigned FB_V = 3;
  localparam int unsigned FB_S = 4;
  localparam int unsigned FB_H = 5;
  localparam int unsigned FB_T = 6;
  localparam int unsigned FB_I = 7;

  typedef struct packed {
    logic known;    // opcode is defined
    logic upd_ch;   // carry/half carry are written
    logic z_chain;  // zero is sticky (carry-chained ops)
    logic c;
    logic h;
    logic v;
    logic n;
    logic z;
  } alu_flags_t;
endpackage

// File: rtl/sf_alu.sv
module sf_alu
  import sf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [3:0]    op_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output alu_flags_t    fl_o
);
  localparam int unsigned HB  = DW / 2;
  localparam int unsigned MSB = DW - 1;

  logic [DW:0]   wide;
  logic [HB:0]   half;
  logic          ci;
  logic [DW-1:0] res;

  assign ci = (op_i == OP_ADC || op_i == OP_SBC) ? cin_i : 1'b0;

  always_comb begin
    wide = '0;
    half = '0;
    res  = '0;
    fl_o = '0;
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        wide = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, ci};
        half = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, ci};
        res  = wide[DW-1:0];
        fl_o.known  = 1'b1;
        fl_o.upd_ch = 1'b1;
        fl_o.c      = wide[DW];
        fl_o.h      = half[HB];
        fl_o.v      = (a_i[MSB] == b_i[MSB]) && (res[MSB] != a_i[MSB]);
      end
      OP_SUB, OP_SBC: begin
        // top bit of the widened difference is the borrow
        wide = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, ci};
        half = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - {{HB{1'b0}}, ci};
        res  = wide[DW-1:0];
        fl_o.known  = 1'b1;
        fl_o.upd_ch = 1'b1;
        fl_o.c      = wide[DW];
        fl_o.h      = half[HB];
        fl_o.v      = (a_i[MSB] != b_i[MSB]) && (res[MSB] != a_i[MSB]);
      end
      OP_AND: begin res = a_i & b_i; fl_o.known = 1'b1; end
      OP_OR:  begin res = a_i | b_i; fl_o.known = 1'b1; end
      OP_XOR: begin res = a_i ^ b_i; fl_o.known = 1'b1; end
      OP_INC: begin
        res = a_i + {{(DW-1){1'b0}}, 1'b1};
        fl_o.known = 1'b1;
        fl_o.v     = (res == {1'b1, {(DW-1){1'b0}}});
      end
      OP_DEC: begin
        res = a_i - {{(DW-1){1'b0}}, 1'b1};
        fl_o.known = 1'b1;
        fl_o.v     = (res == {1'b0, {(DW-1){1'b1}}});
      end
      default: res = '0;
    endcase
    fl_o.z       = (res == '0);
    fl_o.n       = res[MSB];
    fl_o.z_chain = (op_i == OP_ADC || op_i == OP_SBC);
  end

  assign res_o = res;
endmodule

// File: rtl/sf_next.sv
module sf_next
  import sf_pkg::*;
(
  input  logic [SW_W-1:0] cur_i,
  input  logic            alu_fire_i,
  input  alu_flags_t      fl_i,
  input  logic            sw_we_i,
  input  logic [SW_W-1:0] sw_wdata_i,
  input  logic            irq_take_i,
  input  logic            irq_ret_i,
  input  logic            ie_set_i,
  input  logic            ie_clr_i,
  input  logic            bst_i,
  input  logic            bst_bit_i,
  output logic [SW_W-1:0] nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (alu_fire_i && fl_i.known) begin
      nxt_o[FB_V] = fl_i.v;
      nxt_o[FB_N] = fl_i.n;
      nxt_o[FB_S] = fl_i.n ^ fl_i.v;
      nxt_o[FB_Z] = fl_i.z_chain ? (fl_i.z & cur_i[FB_Z]) : fl_i.z;
      if (fl_i.upd_ch) begin
        nxt_o[FB_C] = fl_i.c;
        nxt_o[FB_H] = fl_i.h;
      end
    end
    if (bst_i) nxt_o[FB_T] = bst_bit_i;
    if (irq_ret_i || ie_set_i) nxt_o[FB_I] = 1'b1;
    if (irq_take_i || ie_clr_i) nxt_o[FB_I] = 1'b0;  // clearing wins
    if (sw_we_i) nxt_o = sw_wdata_i;                  // software write wins
  end
endmodule

// File: rtl/sf_status_unit.sv
module sf_status_unit
  import sf_pkg::*;
#(
  parameter  int unsigned DW   = 8,
  localparam int unsigned SELW = $clog2(DW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alu_valid_i,
  input  logic [3:0]      alu_op_i,
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  output logic [DW-1:0]   result_o,
  input  logic            sw_we_i,
  input  logic [SW_W-1:0] sw_wdata_i,
  input  logic            irq_take_i,
  input  logic            irq_ret_i,
  input  logic            ie_set_i,
  input  logic            ie_clr_i,
  input  logic            bst_i,
  input  logic [SELW-1:0] bit_sel_i,
  output logic [DW-1:0]   bld_data_o,
  output logic [SW_W-1:0] status_o
);
  logic [SW_W-1:0] status_q, status_d;
  alu_flags_t      fl;

  sf_alu #(.DW(DW)) i_alu (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .op_i  (alu_op_i),
    .cin_i (status_q[FB_C]),
    .res_o (result_o),
    .fl_o  (fl)
  );

  sf_next i_next (
    .cur_i      (status_q),
    .alu_fire_i (alu_valid_i),
    .fl_i       (fl),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .irq_take_i (irq_take_i),
    .irq_ret_i  (irq_ret_i),
    .ie_set_i   (ie_set_i),
    .ie_clr_i   (ie_clr_i),
    .bst_i      (bst_i),
    .bst_bit_i  (opa_i[bit_sel_i]),
    .nxt_o      (status_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  for (genvar g = 0; g < DW; g++) begin : g_bld
    assign bld_data_o[g] = (bit_sel_i == SELW'(g)) ? status_q[FB_T] : opa_i[g];
  end

  // R2
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> status_o == $past(sw_wdata_i));

  // R3
  sign_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_i && !sw_we_i && (alu_op_i <= 4'd8)
    |=> status_o[FB_S] == (status_o[FB_N] ^ status_o[FB_V]));

  // R7
  logic_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_i && !sw_we_i && (alu_op_i >= 4'd4) && (alu_op_i <= 4'd6)
    |=> $stable(status_o[FB_C]) && $stable(status_o[FB_H]) && !status_o[FB_V]);

  // R9
  ie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i || ie_clr_i) && !sw_we_i |=> !status_o[FB_I]);

  // R9
  ie_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i || ie_set_i) && !irq_take_i && !ie_clr_i && !sw_we_i |=> status_o[FB_I]);

  // R10
  tbit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bst_i && !sw_we_i |=> status_o[FB_T] == $past(opa_i[bit_sel_i]));

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_valid_i && !sw_we_i |=> $stable(status_o[FB_H:FB_C]));
endmodule

// File: tb/test_sf_status_unit.sv
module test_sf_status_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_valid = 1'b0;
  logic [3:0] alu_op = '0;
  logic [7:0] opa = '0, opb = '0;
  logic [7:0] result;
  logic       sw_we = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic       irq_take = 1'b0, irq_ret = 1'b0, ie_set = 1'b0, ie_clr = 1'b0;
  logic       bst = 1'b0;
  logic [2:0] bit_sel = '0;
  logic [7:0] bld_data, status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sf_status_unit i_sf_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .alu_valid_i(alu_valid), .alu_op_i(alu_op),
    .opa_i(opa), .opb_i(opb), .result_o(result), .sw_we_i(sw_we),
    .sw_wdata_i(sw_wdata), .irq_take_i(irq_take), .irq_ret_i(irq_ret),
    .ie_set_i(ie_set), .ie_clr_i(ie_clr), .bst_i(bst), .bit_sel_i(bit_sel),
    .bld_data_o(bld_data), .status_o(status)
  );

  // {prior status, op, a, b, expected result, expected status}
  localparam int NV = 19;
  localparam logic [43:0] VEC [NV] = '{
    {8'h00, 4'd0, 8'h0F, 8'h01, 8'h10, 8'h20},
    {8'h00, 4'd0, 8'h80, 8'h80, 8'h00, 8'h1B},
    {8'h00, 4'd0, 8'h7F, 8'h01, 8'h80, 8'h2C},
    {8'h03, 4'd1, 8'h00, 8'h00, 8'h01, 8'h00},
    {8'h01, 4'd1, 8'hFF, 8'h00, 8'h00, 8'h21},
    {8'h03, 4'd1, 8'hFF, 8'h00, 8'h00, 8'h23},
    {8'h00, 4'd2, 8'h10, 8'h01, 8'h0F, 8'h20},
    {8'h00, 4'd2, 8'h00, 8'h01, 8'hFF, 8'h35},
    {8'h00, 4'd2, 8'h80, 8'h01, 8'h7F, 8'h38},
    {8'h03, 4'd3, 8'h05, 8'h05, 8'hFF, 8'h35},
    {8'h03, 4'd3, 8'h05, 8'h04, 8'h00, 8'h02},
    {8'h29, 4'd4, 8'hF0, 8'h0F, 8'h00, 8'h23},
    {8'hC1, 4'd5, 8'h80, 8'h01, 8'h81, 8'hD5},
    {8'h08, 4'd6, 8'hAA, 8'hAA, 8'h00, 8'h02},
    {8'h21, 4'd7, 8'h7F, 8'h55, 8'h80, 8'h2D},
    {8'h00, 4'd7, 8'hFF, 8'h55, 8'h00, 8'h02},
    {8'h01, 4'd8, 8'h80, 8'h55, 8'h7F, 8'h19},
    {8'h00, 4'd8, 8'h01, 8'h55, 8'h00, 8'h02},
    {8'h5A, 4'd9, 8'h12, 8'h34, 8'h00, 8'h5A}
  };

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0:       return "R4 R3";
      4'd1:       return "R4 R6";
      4'd2:       return "R5 R3";
      4'd3:       return "R5 R6";
      4'd4, 4'd5, 4'd6: return "R7";
      4'd7, 4'd8: return "R8";
      default:    return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    alu_valid = 1'b0; sw_we = 1'b0; irq_take = 1'b0; irq_ret = 1'b0;
    ie_set = 1'b0; ie_clr = 1'b0; bst = 1'b0;
  endtask

  task automatic preset(input logic [7:0] v);
    sw_we = 1'b1; sw_wdata = v;
    tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #13;
    chk("R1 reset", status, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #2;

    for (int i = 0; i < NV; i++) begin
      preset(VEC[i][43:36]);
      alu_valid = 1'b1;
      alu_op = VEC[i][35:32];
      opa = VEC[i][31:24];
      opb = VEC[i][23:16];
      #1;
      chk({op_tag(alu_op), " result"}, result, VEC[i][15:8]);
      tick();
      chk({op_tag(VEC[i][35:32]), " status"}, status, VEC[i][7:0]);
    end

    // R2 write and read back
    preset(8'hA5);
    chk("R2 write", status, 8'hA5);
    // R2 write overrides same-cycle events
    sw_we = 1'b1; sw_wdata = 8'h3C; alu_valid = 1'b1; alu_op = 4'd0;
    opa = 8'h80; opb = 8'h80; ie_set = 1'b1; bst = 1'b1; opa = 8'hFF;
    tick();
    chk("R2 precedence", status, 8'h3C);

    // R12 valid low: result still computed, flags hold
    preset(8'h00);
    alu_op = 4'd0; opa = 8'h80; opb = 8'h80;
    #1;
    chk("R12 comb result", result, 8'h00);
    tick();
    chk("R12 hold", status, 8'h00);

    // R9 interrupt enable control
    preset(8'h7F);
    ie_set = 1'b1; tick();
    chk("R9 set", status, 8'hFF);
    irq_take = 1'b1; tick();
    chk("R9 take", status, 8'h7F);
    irq_ret = 1'b1; tick();
    chk("R9 return", status, 8'hFF);
    ie_clr = 1'b1; tick();
    chk("R9 clear", status, 8'h7F);
    irq_take = 1'b1; ie_set = 1'b1; tick();
    chk("R9 clear wins", status, 8'h7F);

    // R10 bit store
    preset(8'h00);
    bst = 1'b1; opa = 8'h08; bit_sel = 3'd3; tick();
    chk("R10 store one", status, 8'h40);
    bst = 1'b1; opa = 8'hF7; bit_sel = 3'd3; tick();
    chk("R10 store zero", status, 8'h00);

    // R11 bit load
    preset(8'h40);
    opa = 8'h00; bit_sel = 3'd5; #1;
    chk("R11 load one", bld_data, 8'h20);
    preset(8'h00);
    opa = 8'hFF; bit_sel = 3'd0; #1;
    chk("R11 load zero", bld_data, 8'hFE);

    // R1 reset in mid-run
    preset(8'hFF);
    #1 rst_n = 1'b0;
    #1 chk("R1 async reset", status, 8'h00);
    @(posedge clk); #2 rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule